// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, judging only its 48-bit destination address. The receive path presents the address with a one-cycle strobe. A fixed number of cycles later the block returns a one-cycle done pulse and an accept flag, and the flag holds until the next decision.

Four rules settle the decision, in this order:

1. Promiscuous operation keeps every frame.
2. The all-ones address is kept unless a broadcast reject bit is set.
3. Any other group address is looked up in a 64-bit hash table. The table index comes from the CRC-32 of the address.
4. An individual address must equal the programmed station address exactly.

The control bits, the station address and the hash table are loaded through a simple write port. The CRC is computed one address byte per cycle. This keeps the logic depth to eight chained XOR stages.

Top module: `rx_addr_filter`

## Requirements
- R1: Write port map (cfg_addr), with address byte 0 = da[47:40] as the first byte on the wire and byte 5 = da[7:0]:
  - Offset 0 is control. Bit 0 is promiscuous and bit 1 is broadcast reject.
  - Offset 1 holds bytes 2, 3, 4 and 5 in bits 31:24, 23:16, 15:8 and 7:0.
  - Offset 2 holds byte 0 in bits 15:8 and byte 1 in bits 7:0.
  - Offset 3 holds hash bits 0..31 and offset 4 holds hash bits 32..63.
  - Writes to offsets 5 to 7 change nothing.
- R2: After reset, done and accept are 0 and every register is 0.
- R3: done is high for exactly one cycle, on the seventh rising edge after the edge that samples da_valid. accept is updated only on that edge and holds its value until the next done.
- R4: A da_valid strobe that arrives while a decision is in progress is ignored.
- R5: With the promiscuous bit set, every address is accepted.
- R6: If the promiscuous bit is clear, the all-ones address is accepted exactly when the broadcast reject bit is 0, whatever the hash table holds.
- R7: Multicast lookup applies to an address with da[40] = 1 that is not all ones, when the promiscuous bit is clear.
  - The CRC register starts at all ones.
  - Bytes 0 to 5 are shifted in, each least significant bit first, with the reflected polynomial 0xEDB88320 and no final inversion.
  - The frame is accepted exactly when hash bit [crc[31:26]] is 1, so index bit 5 selects the offset 4 register.
- R8: With all 64 hash bits set, every multicast address is accepted.
- R9: An address with da[40] = 0 is accepted, when the promiscuous bit is clear, only if all 48 bits equal the station address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 47:40 |
| done | output | 1 | One-cycle pulse: decision ready |
| accept | output | 1 | 1 = keep the frame, held between decisions |

## Verification
A CRC register that is wrong by one bit moves the hash index, so a table holding a single set bit turns a multicast accept into a reject at the very next done. A bad byte counter shows at once as done arriving off the seventh edge, or arriving twice for one strobe. A mis-split station register fails the exact-match cases on the first decision after it is loaded. The bench therefore drives single-bit hash tables and the neighbouring wrong half-table, alongside near-miss unicast addresses in the first and the last byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int NB      = 6;
    localparam int CFG_AW  = 3;
    localparam int DW      = 32;
    localparam int CRC_W   = 32;
    localparam int HIDX_W  = 6;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

    localparam logic [CFG_AW-1:0] OFS_CTRL   = 3'd0;
    localparam logic [CFG_AW-1:0] OFS_STA_LO = 3'd1;
    localparam logic [CFG_AW-1:0] OFS_STA_HI = 3'd2;
    localparam logic [CFG_AW-1:0] OFS_HASH_L = 3'd3;
    localparam logic [CFG_AW-1:0] OFS_HASH_H = 3'd4;

    localparam int CTRL_PROMISC = 0;
    localparam int CTRL_BC_REJ  = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DECIDE
    } flt_state_e;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int AW = CFG_AW,
    parameter int W  = DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic          promisc,
    output logic          bc_reject,
    output logic [47:0]   station,
    output logic [63:0]   hash
);
    typedef struct packed {
        logic        promisc;
        logic        bc_reject;
        logic [47:0] station;
        logic [63:0] hash;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                OFS_CTRL: begin
                    cfg_d.promisc   = wdata[CTRL_PROMISC];
                    cfg_d.bc_reject = wdata[CTRL_BC_REJ];
                end
                OFS_STA_LO: cfg_d.station[31:0]  = wdata[31:0];
                OFS_STA_HI: cfg_d.station[47:32] = wdata[15:0];
                OFS_HASH_L: cfg_d.hash[31:0]     = wdata[31:0];
                OFS_HASH_H: cfg_d.hash[63:32]    = wdata[31:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign promisc   = cfg_q.promisc;
    assign bc_reject = cfg_q.bc_reject;
    assign station   = cfg_q.station;
    assign hash      = cfg_q.hash;
endmodule

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte
    import rxf_pkg::*;
#(
    parameter int               W    = CRC_W,
    parameter logic [W-1:0]     POLY = CRC_POLY
) (
    input  logic [W-1:0] crc_in,
    input  logic [7:0]   data,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] c;
    logic         fb;

    always_comb begin
        c  = crc_in;
        fb = 1'b0;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ data[i];
            c  = c >> 1;
            if (fb) c = c ^ POLY;
        end
        crc_out = c;
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int AW = CFG_AW,
    parameter int W  = DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [W-1:0]  cfg_wdata,
    input  logic          da_valid,
    input  logic [47:0]   da,
    output logic          done,
    output logic          accept
);
    localparam int IDX_W  = $clog2(NB);
    localparam int ADDR_W = 8 * NB;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

    typedef struct packed {
        flt_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [CRC_W-1:0]  crc;
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic              accept;
    } flt_t;

    flt_t f_d, f_q;

    logic        cfg_promisc;
    logic        cfg_bc_reject;
    logic [47:0] cfg_station;
    logic [63:0] cfg_hash;

    rxf_cfg_regs #(.AW(AW), .W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .promisc   (cfg_promisc),
        .bc_reject (cfg_bc_reject),
        .station   (cfg_station),
        .hash      (cfg_hash)
    );

    logic [ADDR_W-1:0] shifted;
    logic [7:0]        cur_byte;
    logic [CRC_W-1:0]  crc_next;

    assign shifted  = f_q.addr << (8 * f_q.idx);
    assign cur_byte = shifted[ADDR_W-1 -: 8];

    rxf_crc_byte u_crc (
        .crc_in  (f_q.crc),
        .data    (cur_byte),
        .crc_out (crc_next)
    );

    logic              is_bcast, is_mcast, hash_hit, verdict;
    logic [HIDX_W-1:0] hidx;

    always_comb begin
        is_bcast = &f_q.addr;
        is_mcast = f_q.addr[ADDR_W-8];
        hidx     = f_q.crc[CRC_W-1 -: HIDX_W];
        hash_hit = cfg_hash[hidx];
        if (cfg_promisc)   verdict = 1'b1;
        else if (is_bcast) verdict = !cfg_bc_reject;
        else if (is_mcast) verdict = hash_hit;
        else               verdict = (f_q.addr == cfg_station);
    end

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        case (f_q.state)
            ST_IDLE: begin
                if (da_valid) begin
                    f_d.state = ST_RUN;
                    f_d.addr  = da;
                    f_d.crc   = '1;
                    f_d.idx   = '0;
                end
            end
            ST_RUN: begin
                f_d.crc = crc_next;
                f_d.idx = f_q.idx + 1'b1;
                if (f_q.idx == LAST_IDX) f_d.state = ST_DECIDE;
            end
            ST_DECIDE: begin
                f_d.done   = 1'b1;
                f_d.accept = verdict;
                f_d.state  = ST_IDLE;
            end
            default: f_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: ST_IDLE, default: '0};
        else        f_q <= f_d;
    end

    assign done   = f_q.done;
    assign accept = f_q.accept;
endmodule

// File: rtl/rxf_filter_checker.sv
module rxf_filter_checker
    import rxf_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        da_valid,
    input logic [47:0] da,
    input logic        done,
    input logic        accept,
    input logic        promisc,
    input logic        bc_reject,
    input logic [47:0] station
);
    localparam int LAT = NB + 1;

    logic        active_q;
    logic [3:0]  cnt_q;
    logic        exp_q;
    logic [47:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            exp_q    <= 1'b0;
            cap_q    <= '0;
        end else begin
            exp_q <= active_q && (cnt_q == 4'(LAT));
            if (!active_q) begin
                if (da_valid) begin
                    active_q <= 1'b1;
                    cnt_q    <= 4'd1;
                    cap_q    <= da;
                end
            end else if (cnt_q == 4'(LAT)) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 4'd1;
            end
        end
    end

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (done == exp_q));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(accept));

    assert_promisc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(promisc)) |-> accept);

    assert_bcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (&cap_q) && !$past(promisc)) |-> (accept == !$past(bc_reject)));

    assert_unicast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_q[40] && !$past(promisc)) |-> (accept == (cap_q == $past(station))));
endmodule

bind rx_addr_filter rxf_filter_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .da_valid  (da_valid),
    .da        (da),
    .done      (done),
    .accept    (accept),
    .promisc   (cfg_promisc),
    .bc_reject (cfg_bc_reject),
    .station   (cfg_station)
);

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        done, accept;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
        .done(done), .accept(accept)
    );

    typedef struct packed {
        logic [1:0]  ctrl;
        logic [47:0] sta;
        logic [63:0] hash;
        logic [47:0] addr;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
    localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MC1 = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] MC2 = 48'h33_33_00_00_00_01;
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'b00, STA, 64'h0,  STA,                  1'b1, 4'd9}, // R9 match
        '{2'b00, STA, 64'h0,  48'h02_11_22_33_44_54, 1'b0, 4'd9}, // R9 last byte
        '{2'b00, STA, 64'h0,  48'h06_11_22_33_44_55, 1'b0, 4'd9}, // R9 first byte
        '{2'b00, STA, 64'h0,  BC,                   1'b1, 4'd6}, // R6 allowed
        '{2'b10, STA, '1,     BC,                   1'b0, 4'd6}, // R6 rejected
        '{2'b11, STA, 64'h0,  BC,                   1'b1, 4'd5}, // R5 over reject
        '{2'b01, STA, 64'h0,  48'h0A_00_00_00_00_07, 1'b1, 4'd5}, // R5 unicast
        '{2'b01, STA, 64'h0,  MC1,                  1'b1, 4'd5}, // R5 multicast
        '{2'b00, STA, '1,     MC1,                  1'b1, 4'd8}, // R8
        '{2'b00, STA, 64'h0,  MC1,                  1'b0, 4'd7}, // R7 empty table
        '{2'b00, STA, '1,     MC2,                  1'b1, 4'd8}, // R8
        '{2'b00, STA, '1,     48'h02_11_22_33_44_56, 1'b0, 4'd9}, // R9 hash irrelevant
        '{2'b00, STA, 64'h0,  BC,                   1'b1, 4'd6}  // R6 not hashed
    };

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = '1;
        for (int b = 0; b < 6; b++) begin
            logic [7:0] by = a[47 - 8*b -: 8];
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ by[i];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load(input logic [1:0] ctrl, input logic [47:0] s, input logic [63:0] h);
        wr(3'd0, {30'd0, ctrl});
        wr(3'd1, s[31:0]);
        wr(3'd2, {16'd0, s[47:32]});
        wr(3'd3, h[31:0]);
        wr(3'd4, h[63:32]);
    endtask

    task automatic run(input logic [47:0] a, output logic acc, output int lat, output int n_done);
        acc = 1'b0; lat = -1; n_done = 0;
        @(negedge clk);
        da = a; da_valid = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            if (k == 1) da_valid = 1'b0;
            if (done) begin
                n_done++;
                if (lat < 0) begin lat = k; acc = accept; end
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic acc;
        int lat, nd;
        logic [31:0] c;
        logic [5:0] ix;

        repeat (3) @(negedge clk);
        chk("R2", done, 0, "done in reset");
        chk("R2", accept, 0, "accept in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", done, 0, "done after reset");
        // R2: registers cleared: broadcast kept, multicast dropped, zero station matches
        run(BC, acc, lat, nd);
        chk("R2", acc, 1, "broadcast after reset");
        run(MC1, acc, lat, nd);
        chk("R2", acc, 0, "multicast after reset");
        run(48'h0, acc, lat, nd);
        chk("R2", acc, 1, "zero address after reset");

        for (int v = 0; v < NV; v++) begin
            load(VECS[v].ctrl, VECS[v].sta, VECS[v].hash);
            run(VECS[v].addr, acc, lat, nd);
            chk($sformatf("R%0d vec%0d", VECS[v].req, v), acc, VECS[v].exp, "decision");
            chk($sformatf("R3 vec%0d", v), lat, 8, "done cycle");
            chk($sformatf("R3 vec%0d", v), nd, 1, "done count");
        end

        // R3: accept holds after the pulse
        load(2'b00, STA, 64'h0);
        run(STA, acc, lat, nd);
        repeat (4) @(negedge clk);
        chk("R3", accept, 1, "accept held");
        chk("R3", done, 0, "done low between decisions");

        // R7: single set bit, the same bit in the other half, and its complement
        foreach (VECS[v]) begin end
        for (int m = 0; m < 4; m++) begin
            logic [47:0] ma = (m == 0) ? MC1 : (m == 1) ? MC2 :
                              (m == 2) ? 48'h01_80_C2_00_00_0E : 48'h03_12_34_56_78_9A;
            c  = ref_crc(ma);
            ix = c[31:26];
            load(2'b00, STA, 64'h1 << ix);
            run(ma, acc, lat, nd);
            chk("R7", acc, 1, $sformatf("single bit %0d", ix));
            load(2'b00, STA, 64'h1 << (ix ^ 6'd32));
            run(ma, acc, lat, nd);
            chk("R7", acc, 0, $sformatf("other half bit %0d", ix ^ 6'd32));
            load(2'b00, STA, ~(64'h1 << ix));
            run(ma, acc, lat, nd);
            chk("R7", acc, 0, $sformatf("all but bit %0d", ix));
        end

        // R4: second strobe during a decision is dropped
        load(2'b10, STA, 64'h0);
        @(negedge clk);
        da = STA; da_valid = 1'b1;
        nd = 0; lat = -1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            da_valid = (k == 3);
            if (k == 3) da = BC;
            if (done) begin nd++; if (lat < 0) begin lat = k; acc = accept; end end
        end
        chk("R4", nd, 1, "decisions for two strobes");
        chk("R4", lat, 8, "done cycle of first strobe");
        chk("R4", acc, 1, "decision of first strobe");

        // R1: offsets 5..7 change nothing
        load(2'b00, STA, 64'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        run(48'h0A_00_00_00_00_07, acc, lat, nd);
        chk("R1", acc, 0, "unused offsets: unicast miss");
        run(MC1, acc, lat, nd);
        chk("R1", acc, 0, "unused offsets: hash");
        run(STA, acc, lat, nd);
        chk("R1", acc, 1, "unused offsets: station");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule